// File: doc/BRIEF.md
# Coded Output Clock Divider

This block turns an edge-rate timing clock into a divided output clock. The ratio is picked by a 3-bit code, and the result drives two identical output pairs. Each pair has a true output and a complementary output. The block's clock `clk` ticks once for every edge of the fast oscillator, so there are two ticks per oscillator period. A divide ratio of R therefore gives an output period of 2R ticks: R ticks low, then R ticks high. Because every output is a register value that changes only on a tick, the ratio-1 setting is exactly the oscillator waveform, and every ratio has a 50% duty cycle.

The 3-bit code comes from a configuration loader that sits outside this block. The mapping from code to ratio is not monotonic, and some ratios appear twice. A new code is held off until the current output period has ended, so a code change never produces a shortened pulse. An active-low synchronous reset clears the phase counter. While reset is asserted, the true outputs are forced low and the complementary outputs are forced high. Reset does not disturb the code that is applied afterwards.

Top module: `coded_out_div`

## Requirements
- R1: The code selects the ratio R as follows. Codes 0,1,2,3 give R = 2,4,8,16. Codes 4,5,6,7 give R = 1,2,4,8. Code bits are cfg_code[2:0], with bit 2 selecting the upper group.
- R2: Every output high time and every output low time lasts exactly R ticks of `clk`, so the period is 2R ticks at 50% duty.
- R3: All true outputs carry the same value on every tick, and the same holds for all complementary outputs.
- R4: Each complementary output is the bitwise inverse of its true output at all times, including during reset.
- R5: While rst_n is low, every true output is 0 and every complementary output is 1. This takes effect immediately, without waiting for a clock edge.
- R6: Reset clears the phase counter. The first edge after release is phase 1 of a fresh period, whose first R ticks (phases 0..R-1) are low. The output at phase p is 1 exactly when p >= R.
- R7: A code presented while running is adopted only on the edge that ends the current period (phase 2R-1). The new period starts at phase 0, so no high or low time is shorter than the old or new R.
- R8: Any change of the active ratio, including a change to or from ratio 1, happens while the divided output is low.
- R9: While reset is held, the active ratio follows cfg_code. After release the block runs at the code present at the last reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Edge-rate timing clock, one tick per oscillator edge |
| rst_n | input | 1 | Synchronous active-low reset; also gates the outputs directly |
| cfg_code | input | 3 | Ratio code from the configuration loader |
| clk_out | output | NUM_PAIRS | True divided outputs |
| clk_out_n | output | NUM_PAIRS | Complementary divided outputs |

## Verification
The assertions assume that cfg_code is stable across each clock edge and that rst_n is driven to a known level from time zero. The bench meets both conditions by changing inputs only on falling edges and by starting in reset. The stimulus covers every code from reset, and every ordered pair of codes with a mid-period change. It also covers a change of code during reset and a reset asserted in the middle of a period.

// File: rtl/odiv_pkg.sv
// Package: shared widths and the code-to-ratio decode for the coded divider.
// Assumes ratios are powers of two; a ratio is carried as its log2 (shift).
package odiv_pkg;
    localparam int CODE_W    = 3;
    localparam int MAX_SHIFT = 4;                     // largest ratio is 2**MAX_SHIFT
    localparam int CNT_W     = MAX_SHIFT + 1;         // phase counter covers 2*R ticks
    localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);

    typedef logic [SHIFT_W-1:0] shift_t;

    // Map a code to log2 of its ratio: upper group starts at 1, lower at 2.
    function automatic shift_t code_to_shift(input logic [CODE_W-1:0] code);
        return shift_t'({1'b0, code[1:0]}) + shift_t'(!code[2]);
    endfunction
endpackage

// File: rtl/odiv_phase_counter.sv
// Module: phase counter and ratio holder for the coded divider.
// Counts ticks within one output period, adopts a new ratio only when the
// period ends, and registers the divided level from the counter bit that
// matches the active ratio. Assumes cfg_code is stable around clock edges.
module odiv_phase_counter
    import odiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cfg_code,
    output logic              div_level
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] period_mask;
    shift_t           shift_q;
    shift_t           shift_d;
    logic             period_end;
    logic             level_q;

    // Mask of counter bits used by the active ratio (2R-1).
    always_comb begin
        period_mask = {CNT_W{1'b1}} >> (CNT_W - 1 - int'(shift_q));
    end

    // Next phase and next ratio: wrap and adopt new code at period end.
    always_comb begin
        period_end = ((cnt_q & period_mask) == period_mask);
        if (period_end) begin
            cnt_d   = '0;
            shift_d = code_to_shift(cfg_code);
        end else begin
            cnt_d   = cnt_q + 1'b1;
            shift_d = shift_q;
        end
    end

    // State update: reset clears phase and level, ratio follows the code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shift_q <= code_to_shift(cfg_code);
            level_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            shift_q <= shift_d;
            level_q <= cnt_d[shift_d];
        end
    end

    assign div_level = level_q;

    // Ratio changes only while the divided level is low.
    AST_SWITCH_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_q != $past(shift_q)) |-> (level_q == 1'b0)); // R8

    // Ratio changes only at the start of a fresh period.
    AST_ADOPT_AT_PERIOD_END: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_q != $past(shift_q)) |-> (cnt_q == '0)); // R7

    // Phase never leaves the window of the active ratio.
    AST_PHASE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q & ~period_mask) == '0)); // R2
endmodule

// File: rtl/odiv_out_pair.sv
// Module: one output pair. Gates the divided level with reset and makes the
// complementary output. Assumes rst_n is driven from time zero.
module odiv_out_pair (
    input  logic rst_n,
    input  logic div_level,
    output logic pos_out,
    output logic neg_out
);
    // Force the true side low during reset, complement side follows.
    always_comb begin
        pos_out = div_level & rst_n;
        neg_out = ~pos_out;
    end
endmodule

// File: rtl/coded_out_div.sv
// Module: top of the coded output divider. One phase counter feeds
// NUM_PAIRS identical output pairs so that every pair switches together.
// Assumes clk ticks once per oscillator edge; rst_n is active low, synchronous.
module coded_out_div
    import odiv_pkg::*;
#(
    parameter int NUM_PAIRS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CODE_W-1:0]    cfg_code,
    output logic [NUM_PAIRS-1:0] clk_out,
    output logic [NUM_PAIRS-1:0] clk_out_n
);
    logic div_level;

    odiv_phase_counter u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_code (cfg_code),
        .div_level(div_level)
    );

    // One driver per output pair, all fed by the same divided level.
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        odiv_out_pair u_pair (
            .rst_n    (rst_n),
            .div_level(div_level),
            .pos_out  (clk_out[g]),
            .neg_out  (clk_out_n[g])
        );
    end

    // Pairs always agree with each other.
    AST_PAIRS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_out == {NUM_PAIRS{clk_out[0]}})); // R3

    // Complement side is the inverse of the true side.
    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_out_n == ~clk_out)); // R4

    // Reset polarity of both sides, checked on every reset edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_POLARITY: assert ((clk_out == '0) && (clk_out_n == '1)); // R5
        end
    end
endmodule

// File: tb/coded_out_div_bench.sv
// Bench: sweeps every code from reset and every ordered code pair while
// running, against an arithmetic model of phase and ratio.
module coded_out_div_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP         = 2;
    localparam int WATCHDOG   = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cfg_code = 3'd0;
    logic [NP-1:0] clk_out;
    logic [NP-1:0] clk_out_n;

    int errors = 0;
    int checks = 0;
    int m_phase = 0;
    int m_ratio = 2;
    int prev_ratio = 2;
    int run_len = 0;
    bit run_valid = 0;
    logic prev_obs = 1'b0;
    bit done = 0;

    coded_out_div #(.NUM_PAIRS(NP)) u_coded_out_div (
        .clk(clk), .rst_n(rst_n), .cfg_code(cfg_code),
        .clk_out(clk_out), .clk_out_n(clk_out_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ratio_of(input logic [2:0] c);
        return c[2] ? (1 << c[1:0]) : (2 << c[1:0]);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // One tick: update model after the edge, compare at the falling edge.
    task automatic tick(input string tag);
        logic exp;
        @(posedge clk);
        prev_ratio = m_ratio;
        if (!rst_n) begin
            m_phase = 0;
            m_ratio = ratio_of(cfg_code);          // R9
        end else if (m_phase == 2*m_ratio - 1) begin
            m_phase = 0;
            m_ratio = ratio_of(cfg_code);          // R7
        end else begin
            m_phase++;
        end
        @(negedge clk);
        exp = rst_n && (m_phase >= m_ratio);       // R6
        check(clk_out == {NP{exp}}, {tag, " R1 R3 R6 level"}, int'(clk_out), exp ? 3 : 0);
        check(clk_out_n == ~clk_out, {tag, " R4 complement"}, int'(clk_out_n), int'(~clk_out));
        if (!rst_n) begin
            check(clk_out == '0 && clk_out_n == '1, {tag, " R5 reset polarity"},
                  int'({clk_out, clk_out_n}), 3);
            run_valid = 0;
            run_len = 0;
        end else if (clk_out[0] != prev_obs) begin
            if (run_valid)
                check(run_len == prev_ratio, {tag, " R2 R7 run length"}, run_len, prev_ratio);
            run_valid = 1;
            run_len = 1;
        end else begin
            run_len++;
        end
        prev_obs = clk_out[0];
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Reset state; asynchronous effect of reset polarity.
        @(negedge clk);
        check(clk_out == '0 && clk_out_n == '1, "R5 initial", int'(clk_out), 0);
        repeat (3) tick("reset");

        // Every code from reset; code wiggled during reset for R9.
        for (int c = 0; c < 8; c++) begin
            rst_n = 1'b0;
            cfg_code = 3'(c) ^ 3'd5;
            tick("R9 hold");
            cfg_code = 3'(c);
            tick("R9 hold");
            rst_n = 1'b1;
            for (int i = 0; i < 4*ratio_of(3'(c)) + 4; i++) tick("R1 sweep");
        end

        // Every ordered pair of codes, changed at varied offsets (R7 R8).
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                cfg_code = 3'(a);
                for (int i = 0; i < 34; i++) tick("R8 settle");
                for (int i = 0; i < (a*3 + b) % 11; i++) tick("R7 offset");
                cfg_code = 3'(b);
                for (int i = 0; i < 36; i++) tick("R7 switch");
            end
        end

        // Reset in mid-period, then resume from a fresh phase (R6).
        cfg_code = 3'd2;
        for (int i = 0; i < 21; i++) tick("R6 run");
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(clk_out == '0 && clk_out_n == '1, "R5 immediate", int'(clk_out), 0);
        tick("R6 reset");
        rst_n = 1'b1;
        for (int i = 0; i < 40; i++) tick("R6 resume");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule